// File: doc/BRIEF.md
# Lane-Replicating AHB-Lite to APB Bridge

This block connects one AHB-Lite slave port to one APB master port on a single shared clock. Each AHB transfer that is accepted becomes one APB transfer: a setup cycle, then one or more access cycles that last until the addressed APB slave raises its ready. The AHB side is stalled with its ready output low for the whole APB transfer. On completion the response is OKAY, or a two-cycle ERROR if the slave reported an error.

The APB side is always 32 bits wide. A narrow AHB write (byte or half-word) becomes a full-word APB write. The narrow value is taken from the AHB write lane selected by the low address bits and copied into every lane of the APB write word. A read returns the whole APB word, and the AHB master picks out its own lane.

The bridge also decodes addresses for a parameterised number of APB slaves. Each slave owns one 1 KB window in a region starting at a base address. The bridge drives a one-hot select vector. An address outside every window gets an ERROR response, and no APB transfer takes place.

Top module: `apb_lane_bridge`

## Requirements
- R1: While reset is asserted and after it is released, `hreadyout` is 1, `hresp` is 0, `psel` is all zero and `penable` is 0.
- R2: An address phase is accepted when `hsel` is 1, `htrans` is NONSEQ (2'b10) or SEQ (2'b11), `hready` is 1 and the bridge is ready. In the next cycle it is a setup cycle: exactly one `psel` bit is set, `penable` is 0, `pwrite` equals the captured `hwrite`, and `paddr` equals the captured address with bits [1:0] cleared. `pready` during setup has no effect.
- R3: The access phase begins in the cycle after setup with `penable` 1. `psel`, `paddr` and `pwdata` stay stable until a cycle in which `pready` is 1.
- R4: `hreadyout` is 0 from the cycle after acceptance up to and including the last access cycle. In the cycle after `pready` without `pslverr`, `hreadyout` is 1 and `hresp` is 0 (OKAY).
- R5: Byte write (`hsize`=0): the byte on `hwdata[8*a+7:8*a]`, where a is the address bits [1:0], appears in all four bytes of `pwdata` (little-endian lane numbering).
- R6: Half-word write (`hsize`=1): the half on `hwdata[16*b+15:16*b]`, where b is address bit 1, appears in both halves of `pwdata`.
- R7: Word write (`hsize`=2): `pwdata` equals `hwdata` unchanged.
- R8: A read drives `pwrite` 0. In the cycle after `pready`, `hrdata` equals the full `prdata` word sampled with `pready`.
- R9: `pslverr` with `pready` gives a two-cycle ERROR. In the first cycle `hresp`=1 and `hreadyout`=0. In the second cycle `hresp`=1 and `hreadyout`=1.
- R10: Slave i is selected when address bits [31:13] match the base address (0x4000_0000 by default) and bits [12:10] equal i, with i below NUM_SLV (6). Any other address produces the R9 two-cycle ERROR, starting in the cycle after acceptance, with `psel` all zero throughout.
- R11: An address phase with `hsel` 0, with `htrans` IDLE (2'b00) or BUSY (2'b01), or with `hready` 0 starts no APB transfer: `psel` stays zero and `hreadyout` stays 1.
- R12: An address phase presented in the cycle where `hreadyout` returns to 1 after an OKAY completion is accepted. Its setup cycle follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both bus sides |
| rst_n | input | 1 | Active-low synchronous reset |
| hsel | input | 1 | AHB slave select for this bridge |
| haddr | input | 32 | AHB byte address |
| htrans | input | 2 | AHB transfer type |
| hwrite | input | 1 | AHB write (1) or read (0) |
| hsize | input | 3 | AHB transfer size: 0 byte, 1 half, 2 word |
| hwdata | input | 32 | AHB write data, valid in the data phase |
| hready | input | 1 | AHB bus-wide ready (previous transfer done) |
| hreadyout | output | 1 | Bridge ready toward the AHB bus |
| hresp | output | 1 | AHB response: 0 OKAY, 1 ERROR |
| hrdata | output | 32 | AHB read data |
| psel | output | NUM_SLV | One-hot APB slave selects |
| penable | output | 1 | APB access-phase strobe |
| paddr | output | 32 | APB word address |
| pwrite | output | 1 | APB write (1) or read (0) |
| pwdata | output | 32 | APB write word with replicated lanes |
| pready | input | 1 | APB ready from the selected slave |
| prdata | input | 32 | APB read data from the selected slave |
| pslverr | input | 1 | APB error from the selected slave |

## Verification
The properties assume an AHB master that holds `hwdata` steady for the whole data phase. They also assume the master presents no new address phase while `hreadyout` is low, and an APB slave whose `pready`, `pslverr` and `prdata` matter only during access cycles. The stimulus changes every input only on falling clock edges. It keeps `hwdata` fixed from the setup cycle until completion, and it idles the AHB request lines once each address phase is taken. It raises `pready` in setup once, only to show that value is ignored.

// File: rtl/apb_lane_bridge_pkg.sv
package apb_lane_bridge_pkg;
   typedef enum logic [2:0] {
      BR_IDLE   = 3'd0,
      BR_SETUP  = 3'd1,
      BR_ACCESS = 3'd2,
      BR_ERR1   = 3'd3,
      BR_ERR2   = 3'd4
   } br_state_e;

   localparam logic [2:0] SZ_BYTE = 3'd0;
   localparam logic [2:0] SZ_HALF = 3'd1;
   localparam logic [1:0] TR_NONSEQ = 2'b10;
   localparam logic [1:0] TR_SEQ    = 2'b11;
endpackage

// File: rtl/apb_slot_decode.sv
module apb_slot_decode #(
   parameter int ADDR_W  = 32,
   parameter int NUM_SLV = 6,
   parameter int WIN_LSB = 10,
   parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
   localparam int IDX_W = $clog2(NUM_SLV)
) (
   input  logic [ADDR_W-1:WIN_LSB] addr_hi,
   output logic [NUM_SLV-1:0]      hit_vec
);
   logic             region_ok;
   logic [IDX_W-1:0] slot_idx;

   assign region_ok = (addr_hi[ADDR_W-1:WIN_LSB+IDX_W] == BASE_ADDR[ADDR_W-1:WIN_LSB+IDX_W]);
   assign slot_idx  = addr_hi[WIN_LSB +: IDX_W];

   for (genvar i = 0; i < NUM_SLV; i++) begin : g_slot
      assign hit_vec[i] = region_ok && (slot_idx == IDX_W'(i));
   end
endmodule

// File: rtl/apb_lane_fan.sv
module apb_lane_fan #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int LSB_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [LSB_W-1:0]  addr_lo,
   input  logic [2:0]        size,
   output logic [DATA_W-1:0] dout
);
   import apb_lane_bridge_pkg::*;

   logic [7:0]  byte_src;
   logic [15:0] half_src;

   assign byte_src = din[{addr_lo, 3'b000} +: 8];
   assign half_src = din[{addr_lo[LSB_W-1], 4'b0000} +: 16];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_comb begin
         case (size)
            SZ_BYTE: dout[8*l +: 8] = byte_src;
            SZ_HALF: dout[8*l +: 8] = half_src[8*(l%2) +: 8];
            default: dout[8*l +: 8] = din[8*l +: 8];
         endcase
      end
   end
endmodule

// File: rtl/apb_bridge_ctrl.sv
module apb_bridge_ctrl #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int NUM_SLV = 6,
   localparam int LSB_W  = $clog2(DATA_W / 8)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hsel,
   input  logic [1:0]         htrans,
   input  logic               hready,
   input  logic [ADDR_W-1:0]  haddr,
   input  logic               hwrite,
   input  logic [2:0]         hsize,
   input  logic [NUM_SLV-1:0] hit_vec,
   input  logic [DATA_W-1:0]  wdata_rep,
   input  logic               pready,
   input  logic [DATA_W-1:0]  prdata,
   input  logic               pslverr,
   output logic               hreadyout,
   output logic               hresp,
   output logic [DATA_W-1:0]  hrdata,
   output logic [NUM_SLV-1:0] psel,
   output logic               penable,
   output logic [ADDR_W-1:0]  paddr,
   output logic               pwrite,
   output logic [DATA_W-1:0]  pwdata,
   output logic [LSB_W-1:0]   addr_lo,
   output logic [2:0]         size_q
);
   import apb_lane_bridge_pkg::*;

   br_state_e          state, state_nx;
   logic [ADDR_W-1:0]  addr_q;
   logic               write_q;
   logic [NUM_SLV-1:0] sel_q;
   logic [DATA_W-1:0]  wdata_q;
   logic [DATA_W-1:0]  rdata_q;
   logic               can_take;
   logic               take;

   assign can_take = (state == BR_IDLE) || (state == BR_ERR2);
   assign take     = can_take && hsel && hready &&
                     ((htrans == TR_NONSEQ) || (htrans == TR_SEQ));

   always_comb begin
      state_nx = state;
      case (state)
         BR_IDLE, BR_ERR2: begin
            if (take)                 state_nx = (|hit_vec) ? BR_SETUP : BR_ERR1;
            else                      state_nx = BR_IDLE;
         end
         BR_SETUP:                    state_nx = BR_ACCESS;
         BR_ACCESS: if (pready)       state_nx = pslverr ? BR_ERR1 : BR_IDLE;
         BR_ERR1:                     state_nx = BR_ERR2;
         default:                     state_nx = BR_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= BR_IDLE;
         addr_q  <= '0;
         write_q <= 1'b0;
         size_q  <= '0;
         sel_q   <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         state <= state_nx;
         if (take) begin
            addr_q  <= haddr;
            write_q <= hwrite;
            size_q  <= hsize;
            sel_q   <= hit_vec;
         end
         if (state == BR_SETUP)
            wdata_q <= wdata_rep;
         if ((state == BR_ACCESS) && pready)
            rdata_q <= prdata;
      end
   end

   assign hreadyout = (state == BR_IDLE) || (state == BR_ERR2);
   assign hresp     = (state == BR_ERR1) || (state == BR_ERR2);
   assign hrdata    = rdata_q;
   assign psel      = ((state == BR_SETUP) || (state == BR_ACCESS)) ? sel_q : '0;
   assign penable   = (state == BR_ACCESS);
   assign paddr     = {addr_q[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
   assign pwrite    = write_q;
   assign pwdata    = (state == BR_SETUP) ? wdata_rep : wdata_q;
   assign addr_lo   = addr_q[LSB_W-1:0];
endmodule

// File: rtl/apb_lane_bridge.sv
module apb_lane_bridge #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int NUM_SLV = 6,
   parameter int WIN_LSB = 10,
   parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hsel,
   input  logic [ADDR_W-1:0]  haddr,
   input  logic [1:0]         htrans,
   input  logic               hwrite,
   input  logic [2:0]         hsize,
   input  logic [DATA_W-1:0]  hwdata,
   input  logic               hready,
   output logic               hreadyout,
   output logic               hresp,
   output logic [DATA_W-1:0]  hrdata,
   output logic [NUM_SLV-1:0] psel,
   output logic               penable,
   output logic [ADDR_W-1:0]  paddr,
   output logic               pwrite,
   output logic [DATA_W-1:0]  pwdata,
   input  logic               pready,
   input  logic [DATA_W-1:0]  prdata,
   input  logic               pslverr
);
   localparam int LSB_W = $clog2(DATA_W / 8);
   localparam int IDX_W = $clog2(NUM_SLV);

   if (DATA_W != 32) begin : g_bad_width
      $error("apb_lane_bridge: DATA_W must be 32");
   end
   if (ADDR_W != 32) begin : g_bad_addr
      $error("apb_lane_bridge: ADDR_W must be 32");
   end
   if (NUM_SLV < 2) begin : g_bad_count
      $error("apb_lane_bridge: NUM_SLV must be at least 2");
   end
   if (WIN_LSB + IDX_W >= ADDR_W) begin : g_bad_window
      $error("apb_lane_bridge: slave windows exceed the address width");
   end

   logic [NUM_SLV-1:0] hit_vec;
   logic [DATA_W-1:0]  wdata_rep;
   logic [LSB_W-1:0]   addr_lo;
   logic [2:0]         size_q;

   apb_slot_decode #(
      .ADDR_W(ADDR_W), .NUM_SLV(NUM_SLV), .WIN_LSB(WIN_LSB), .BASE_ADDR(BASE_ADDR)
   ) u_decode (
      .addr_hi (haddr[ADDR_W-1:WIN_LSB]),
      .hit_vec (hit_vec)
   );

   apb_lane_fan #(.DATA_W(DATA_W)) u_fan (
      .din     (hwdata),
      .addr_lo (addr_lo),
      .size    (size_q),
      .dout    (wdata_rep)
   );

   apb_bridge_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLV(NUM_SLV)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .hsel      (hsel),
      .htrans    (htrans),
      .hready    (hready),
      .haddr     (haddr),
      .hwrite    (hwrite),
      .hsize     (hsize),
      .hit_vec   (hit_vec),
      .wdata_rep (wdata_rep),
      .pready    (pready),
      .prdata    (prdata),
      .pslverr   (pslverr),
      .hreadyout (hreadyout),
      .hresp     (hresp),
      .hrdata    (hrdata),
      .psel      (psel),
      .penable   (penable),
      .paddr     (paddr),
      .pwrite    (pwrite),
      .pwdata    (pwdata),
      .addr_lo   (addr_lo),
      .size_q    (size_q)
   );
endmodule

// File: rtl/apb_lane_bridge_chk.sv
module apb_lane_bridge_chk #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int NUM_SLV = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               hsel,
   input logic [1:0]         htrans,
   input logic               hready,
   input logic               hreadyout,
   input logic               hresp,
   input logic [NUM_SLV-1:0] psel,
   input logic               penable,
   input logic [ADDR_W-1:0]  paddr,
   input logic [DATA_W-1:0]  pwdata,
   input logic               pready,
   input logic               pslverr
);
   p_psel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(psel));

   p_setup_then_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((|psel) && !penable) |=> penable);

   p_access_has_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      penable |-> (|psel));

   p_access_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (penable && !pready) |=> (penable && $stable(psel) && $stable(paddr) && $stable(pwdata)));

   p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      penable |-> !hreadyout);

   p_okay_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (penable && pready && !pslverr) |=> (hreadyout && !hresp));

   p_err_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (penable && pready && pslverr) |=> (hresp && !hreadyout));

   p_err_second_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hresp && !hreadyout) |=> (hresp && hreadyout));

   p_no_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (hreadyout && !(hsel && hready && htrans[1])) |=> (psel == '0));
endmodule

bind apb_lane_bridge apb_lane_bridge_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLV(NUM_SLV)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hsel      (hsel),
   .htrans    (htrans),
   .hready    (hready),
   .hreadyout (hreadyout),
   .hresp     (hresp),
   .psel      (psel),
   .penable   (penable),
   .paddr     (paddr),
   .pwdata    (pwdata),
   .pready    (pready),
   .pslverr   (pslverr)
);

// File: tb/apb_lane_bridge_test.sv
module apb_lane_bridge_test;
   localparam int NS = 6;
   localparam logic [31:0] BASE = 32'h4000_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hsel = 1'b0;
   logic [31:0]   haddr = '0;
   logic [1:0]    htrans = 2'b00;
   logic          hwrite = 1'b0;
   logic [2:0]    hsize = 3'd2;
   logic [31:0]   hwdata = '0;
   logic          hready = 1'b1;
   logic          hreadyout, hresp, penable, pwrite;
   logic [31:0]   hrdata, paddr, pwdata;
   logic [NS-1:0] psel;
   logic          pready = 1'b0;
   logic [31:0]   prdata = '0;
   logic          pslverr = 1'b0;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   apb_lane_bridge #(.NUM_SLV(NS), .BASE_ADDR(BASE)) uut (
      .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
      .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
      .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata), .psel(psel),
      .penable(penable), .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata),
      .pready(pready), .prdata(prdata), .pslverr(pslverr)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // One AHB transfer with a behavioural APB slave. Inputs change on falling edges.
   task automatic xfer(input string wreq, input logic [31:0] addr, input bit wr,
                       input logic [2:0] sz, input logic [31:0] wd, input int waits,
                       input bit err, input logic [31:0] rd, input bit setup_rdy,
                       input bit now, input int slot, input logic [31:0] exp_pw);
      logic [NS-1:0] exp_sel;
      if (!now) @(negedge clk);
      hsel = 1'b1; htrans = 2'b10; haddr = addr; hwrite = wr; hsize = sz; hready = 1'b1;
      @(negedge clk);
      hsel = 1'b0; htrans = 2'b00; hwdata = wd; pready = setup_rdy; pslverr = 1'b0;
      #1;
      if (slot < 0) begin
         chk("R10", "miss psel", 32'(psel), 32'd0);
         chk("R10", "miss err1 hresp", 32'(hresp), 32'd1);
         chk("R10", "miss err1 hreadyout", 32'(hreadyout), 32'd0);
         @(negedge clk); pready = 1'b0; #1;
         chk("R10", "miss err2 hresp", 32'(hresp), 32'd1);
         chk("R10", "miss err2 hreadyout", 32'(hreadyout), 32'd1);
         chk("R10", "miss err2 psel", 32'(psel), 32'd0);
         return;
      end
      exp_sel = NS'(1) << slot;
      chk("R2", "setup psel", 32'(psel), 32'(exp_sel));
      chk("R2", "setup penable", 32'(penable), 32'd0);
      chk("R2", "setup paddr", paddr, {addr[31:2], 2'b00});
      chk("R2", "setup pwrite", 32'(pwrite), 32'(wr));
      chk("R4", "setup hreadyout", 32'(hreadyout), 32'd0);
      if (wr) chk(wreq, "setup pwdata", pwdata, exp_pw);
      for (int k = 0; k <= waits; k++) begin
         @(negedge clk);
         #1;
         chk("R3", "access penable", 32'(penable), 32'd1);
         chk("R3", "access psel", 32'(psel), 32'(exp_sel));
         chk("R3", "access paddr", paddr, {addr[31:2], 2'b00});
         if (wr) chk(wreq, "access pwdata", pwdata, exp_pw);
         chk("R4", "access hreadyout", 32'(hreadyout), 32'd0);
         pready = (k == waits);
         pslverr = err && (k == waits);
         prdata = rd;
      end
      @(negedge clk);
      pready = 1'b0; pslverr = 1'b0;
      #1;
      if (err) begin
         chk("R9", "err1 hresp", 32'(hresp), 32'd1);
         chk("R9", "err1 hreadyout", 32'(hreadyout), 32'd0);
         @(negedge clk); #1;
         chk("R9", "err2 hresp", 32'(hresp), 32'd1);
         chk("R9", "err2 hreadyout", 32'(hreadyout), 32'd1);
      end else begin
         chk("R4", "done hreadyout", 32'(hreadyout), 32'd1);
         chk("R4", "done hresp", 32'(hresp), 32'd0);
         chk("R4", "done psel", 32'(psel), 32'd0);
         if (!wr) chk("R8", "read hrdata", hrdata, rd);
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "in reset hreadyout", 32'(hreadyout), 32'd1);
      chk("R1", "in reset psel", 32'(psel), 32'd0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1", "after reset hreadyout", 32'(hreadyout), 32'd1);
      chk("R1", "after reset hresp", 32'(hresp), 32'd0);
      chk("R1", "after reset psel", 32'(psel), 32'd0);
      chk("R1", "after reset penable", 32'(penable), 32'd0);
   endtask

   task automatic t_word_write();
      xfer("R7", BASE + 32'h808, 1'b1, 3'd2, 32'hDEAD_BEEF, 0, 1'b0, '0, 1'b0, 1'b0, 2, 32'hDEAD_BEEF);
   endtask

   task automatic t_byte_write();
      xfer("R5", BASE + 32'h403, 1'b1, 3'd0, 32'hA1B2_C3D4, 1, 1'b0, '0, 1'b0, 1'b0, 1, 32'hA1A1_A1A1);
      xfer("R5", BASE + 32'h401, 1'b1, 3'd0, 32'h1122_3344, 0, 1'b0, '0, 1'b0, 1'b0, 1, 32'h3333_3333);
   endtask

   task automatic t_half_write();
      xfer("R6", BASE + 32'h1402, 1'b1, 3'd1, 32'h5566_7788, 0, 1'b0, '0, 1'b0, 1'b0, 5, 32'h5566_5566);
      xfer("R6", BASE + 32'h1400, 1'b1, 3'd1, 32'h5566_7788, 2, 1'b0, '0, 1'b0, 1'b0, 5, 32'h7788_7788);
   endtask

   task automatic t_read_waits();
      // pready high during setup must not shorten the transfer (R2)
      xfer("R8", BASE + 32'h002, 1'b0, 3'd0, '0, 3, 1'b0, 32'hCAFE_F00D, 1'b1, 1'b0, 0, '0);
   endtask

   task automatic t_slave_error();
      xfer("R7", BASE + 32'hC00, 1'b1, 3'd2, 32'h0BAD_0BAD, 1, 1'b1, '0, 1'b0, 1'b0, 3, 32'h0BAD_0BAD);
   endtask

   task automatic t_decode_miss();
      xfer("R10", BASE + 32'h1800, 1'b1, 3'd2, 32'h1, 0, 1'b0, '0, 1'b0, 1'b0, -1, '0);
      xfer("R10", 32'h5000_0400, 1'b0, 3'd2, '0, 0, 1'b0, '0, 1'b0, 1'b0, -1, '0);
   endtask

   task automatic t_back_to_back();
      xfer("R7", BASE + 32'h1000, 1'b1, 3'd2, 32'h0102_0304, 0, 1'b0, '0, 1'b0, 1'b0, 4, 32'h0102_0304);
      // R12: next address phase presented in the completion cycle
      xfer("R12", BASE + 32'h1004, 1'b0, 3'd2, '0, 0, 1'b0, 32'h8765_4321, 1'b0, 1'b1, 4, '0);
   endtask

   task automatic t_ignored();
      @(negedge clk);
      hsel = 1'b1; htrans = 2'b01; haddr = BASE; hwrite = 1'b1; hready = 1'b1;
      @(negedge clk); #1;
      chk("R11", "busy psel", 32'(psel), 32'd0);
      chk("R11", "busy hreadyout", 32'(hreadyout), 32'd1);
      hsel = 1'b0; htrans = 2'b10;
      @(negedge clk); #1;
      chk("R11", "unselected psel", 32'(psel), 32'd0);
      hsel = 1'b1; hready = 1'b0;
      @(negedge clk); #1;
      chk("R11", "hready low psel", 32'(psel), 32'd0);
      chk("R11", "hready low hreadyout", 32'(hreadyout), 32'd1);
      hsel = 1'b0; htrans = 2'b00; hready = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_word_write();
      t_byte_write();
      t_half_write();
      t_read_waits();
      t_slave_error();
      t_decode_miss();
      t_back_to_back();
      t_ignored();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule